// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block collects interrupt requests from shared hardware lines, from per-CPU private timer and watchdog sources, and from software-triggered inter-processor requests. It routes them to a cluster of one to four CPUs. Software configures each interrupt ID through a single-cycle register port. For each ID it sets an enable bit and a 4-bit priority, and for shared IDs a target-CPU mask. For each CPU it sets a priority mask and a binary-point value that divides the priority into a preemption group and a subpriority.

Each CPU sees an `irq_o` line that is raised while an interrupt qualifies for it. The CPU pulses `ack_i` to claim the best candidate. The claimed ID and its requester appear on the registered acknowledge outputs in the next cycle, and the interrupt moves from pending to active. Writing the ID back through the end-of-interrupt port retires it. The CPU's running priority then falls back to that of its highest remaining active interrupt.

ID map: 0 to 15 are software IDs, banked per CPU. 29 is the private timer and 30 the private watchdog. Shared line n is ID 32+n. ID 1023 means spurious.

Top module: `mpid_top`

## Requirements
- R1: After reset every `irq_o` bit is 0, an acknowledge returns ID 1023, every ID config word reads 0, and each CPU settings word reads 0x00F (mask 15, binary point 0).
- R2: An ID config word at address = ID holds enable in bit 0, priority in bits 7:4 and, for shared IDs only, the target mask in bits 8+NUM_CPU-1:8. For IDs below 32 the target bits are ignored and read as 0. The CPU settings word at 0x3F8+cpu holds the priority mask in bits 3:0 and the binary point in bits 9:8.
- R3: A rising edge on shared line n makes ID 32+n pending one clock later. It is signalled only to CPUs whose bit is set in its target mask.
- R4: Among candidates the lowest numeric priority wins, and equal priorities resolve to the lowest ID.
- R5: A candidate is signalled only if its priority is numerically below the CPU's mask. Otherwise an acknowledge returns 1023 and changes nothing.
- R6: A disabled ID still becomes pending but is never signalled. Enabling it later delivers it.
- R7: An acknowledge returns the ID (and source CPU in bits 1:0 of `ack_src_o`, 0 for hardware sources) on the next cycle and moves the ID from pending to active.
- R8: With an interrupt active, a new candidate is signalled only if its priority shifted right by the binary point is below the running priority shifted the same way.
- R9: End-of-interrupt clears the active state. The running priority returns to the lowest priority value among the remaining active IDs.
- R10: A write to 0x3F0 raises software ID wdata[3:0]. Mode wdata[17:16] selects the targets: 0 uses the CPU list in wdata[8+NUM_CPU-1:8], 1 targets all CPUs but the requester `reg_cpu_i`, 2 targets only the requester, and 3 does nothing. The acknowledge reports the requester as the source.
- R11: The rising edge of `timer_i[c]` (ID 29) or `wdog_i[c]` (ID 30) pends only on CPU c.
- R12: When several CPUs acknowledge the same shared ID in one cycle, the lowest-numbered CPU receives it and the others receive 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_cpu_i | input | 2 | CPU issuing the access |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| spi_i | input | NUM_SPI (min 1) | Shared hardware lines, rising-edge |
| timer_i | input | NUM_CPU | Private timer requests |
| wdog_i | input | NUM_CPU | Private watchdog requests |
| irq_o | output | NUM_CPU | Interrupt signal per CPU |
| ack_i | input | NUM_CPU | Acknowledge pulse per CPU |
| ack_id_o | output | NUM_CPU*10 | Acknowledged ID per CPU |
| ack_src_o | output | NUM_CPU*2 | Requesting CPU of acknowledged ID |
| eoi_i | input | NUM_CPU | End-of-interrupt pulse per CPU |
| eoi_id_i | input | NUM_CPU*10 | ID being retired per CPU |

## Verification
The acknowledge of one CPU and the acknowledge of another CPU on the same shared ID can fall in the same cycle. Both claim the ID they see as best. The bench sets up a shared ID that targets both CPUs and raises both `ack_i` bits in the same cycle. It then checks that CPU 0 receives the ID, that CPU 1 receives 1023, and that both `irq_o` bits drop afterwards. A further scenario applies end-of-interrupt for a nested interrupt and then re-raises the same source. This shows whether the running priority was restored correctly.

// File: rtl/mpid_pkg.sv
package mpid_pkg;
  localparam int ID_W      = 10;
  localparam int PRIO_W    = 4;
  localparam int CPU_W     = 2;
  localparam int SGI_N     = 16;
  localparam int ID_TIMER  = 29;
  localparam int ID_WDOG   = 30;
  localparam int SPI_BASE  = 32;
  localparam int ADDR_W    = 10;
  localparam logic [ID_W-1:0]   SPURIOUS = 10'd1023;
  localparam logic [ADDR_W-1:0] SGI_ADDR = 10'h3F0;
  localparam logic [ADDR_W-1:0] CPU_BASE = 10'h3F8;

  typedef enum logic [1:0] {
    SGI_LIST   = 2'd0,
    SGI_OTHERS = 2'd1,
    SGI_SELF   = 2'd2,
    SGI_NONE   = 2'd3
  } sgi_mode_e;
endpackage

// File: rtl/mpid_regs.sv
module mpid_regs
  import mpid_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 8,
  localparam int TOTAL  = SPI_BASE + NUM_SPI,
  localparam int SPI_W  = (NUM_SPI > 0) ? NUM_SPI : 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [31:0]                          wdata_i,
  input  logic [CPU_W-1:0]                     cpu_i,
  output logic [31:0]                          rdata_o,
  output logic [TOTAL-1:0]                     en_o,
  output logic [TOTAL-1:0][PRIO_W-1:0]         prio_o,
  output logic [SPI_W-1:0][NUM_CPU-1:0]        tgt_o,
  output logic [NUM_CPU-1:0][PRIO_W-1:0]       mask_o,
  output logic [NUM_CPU-1:0][1:0]              bp_o,
  output logic                                 sgi_vld_o,
  output logic [3:0]                           sgi_id_o,
  output logic [NUM_CPU-1:0]                   sgi_tgt_o,
  output logic [CPU_W-1:0]                     sgi_src_o
);
  logic [NUM_CPU-1:0] self_m, tg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      prio_o <= '0;
      tgt_o  <= '0;
      bp_o   <= '0;
      for (int c = 0; c < NUM_CPU; c++) mask_o[c] <= '1;
    end else if (we_i) begin
      for (int i = 0; i < TOTAL; i++)
        if (addr_i == ADDR_W'(i)) begin
          en_o[i]   <= wdata_i[0];
          prio_o[i] <= wdata_i[7:4];
        end
      for (int i = 0; i < NUM_SPI; i++)
        if (addr_i == ADDR_W'(SPI_BASE + i)) tgt_o[i] <= wdata_i[8 +: NUM_CPU];
      for (int c = 0; c < NUM_CPU; c++)
        if (addr_i == CPU_BASE + ADDR_W'(c)) begin
          mask_o[c] <= wdata_i[3:0];
          bp_o[c]   <= wdata_i[9:8];
        end
    end
  end

  // software request target filter
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) self_m[c] = (cpu_i == CPU_W'(c));
    case (sgi_mode_e'(wdata_i[17:16]))
      SGI_LIST:   tg = wdata_i[8 +: NUM_CPU];
      SGI_OTHERS: tg = ~self_m;
      SGI_SELF:   tg = self_m;
      default:    tg = '0;
    endcase
    sgi_vld_o = we_i && (addr_i == SGI_ADDR) && (|tg);
    sgi_id_o  = wdata_i[3:0];
    sgi_tgt_o = tg;
    sgi_src_o = cpu_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < TOTAL; i++)
      if (addr_i == ADDR_W'(i)) begin
        rdata_o[0]   = en_o[i];
        rdata_o[7:4] = prio_o[i];
      end
    for (int i = 0; i < NUM_SPI; i++)
      if (addr_i == ADDR_W'(SPI_BASE + i)) rdata_o[8 +: NUM_CPU] = tgt_o[i];
    for (int c = 0; c < NUM_CPU; c++)
      if (addr_i == CPU_BASE + ADDR_W'(c)) begin
        rdata_o[3:0] = mask_o[c];
        rdata_o[9:8] = bp_o[c];
      end
  end
endmodule

// File: rtl/mpid_state.sv
module mpid_state
  import mpid_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 8,
  localparam int TOTAL  = SPI_BASE + NUM_SPI,
  localparam int SPI_W  = (NUM_SPI > 0) ? NUM_SPI : 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [SPI_W-1:0]                       spi_i,
  input  logic [NUM_CPU-1:0]                     timer_i,
  input  logic [NUM_CPU-1:0]                     wdog_i,
  input  logic [SPI_W-1:0][NUM_CPU-1:0]          tgt_i,
  input  logic                                   sgi_vld_i,
  input  logic [3:0]                             sgi_id_i,
  input  logic [NUM_CPU-1:0]                     sgi_tgt_i,
  input  logic [CPU_W-1:0]                       sgi_src_i,
  input  logic [NUM_CPU-1:0]                     grant_i,
  input  logic [NUM_CPU-1:0][ID_W-1:0]           grant_id_i,
  input  logic [NUM_CPU-1:0]                     eoi_i,
  input  logic [NUM_CPU-1:0][ID_W-1:0]           eoi_id_i,
  output logic [NUM_CPU-1:0][TOTAL-1:0]          pend_o,
  output logic [NUM_CPU-1:0][TOTAL-1:0]          act_o,
  output logic [NUM_CPU-1:0][SGI_N-1:0][CPU_W-1:0] sgi_src_o
);
  logic [NUM_CPU-1:0][SGI_N-1:0] sgi_pend_q, sgi_act_q;
  logic [NUM_CPU-1:0][1:0]       ppi_pend_q, ppi_act_q;
  logic [NUM_CPU-1:0]            tmr_q, wdg_q;
  logic [SPI_W-1:0]              spi_q, spi_pend_q, spi_act_q;
  logic [SPI_W-1:0][CPU_W-1:0]   spi_own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sgi_pend_q <= '0; sgi_act_q <= '0; sgi_src_o <= '0;
      ppi_pend_q <= '0; ppi_act_q <= '0;
      tmr_q <= '0; wdg_q <= '0; spi_q <= '0;
      spi_pend_q <= '0; spi_act_q <= '0; spi_own_q <= '0;
    end else begin
      tmr_q <= timer_i;
      wdg_q <= wdog_i;
      spi_q <= spi_i;
      for (int c = 0; c < NUM_CPU; c++) begin
        if (eoi_i[c]) begin
          for (int i = 0; i < SGI_N; i++)
            if (eoi_id_i[c] == ID_W'(i)) sgi_act_q[c][i] <= 1'b0;
          if (eoi_id_i[c] == ID_W'(ID_TIMER)) ppi_act_q[c][0] <= 1'b0;
          if (eoi_id_i[c] == ID_W'(ID_WDOG))  ppi_act_q[c][1] <= 1'b0;
          for (int i = 0; i < NUM_SPI; i++)
            if (eoi_id_i[c] == ID_W'(SPI_BASE + i) && spi_own_q[i] == CPU_W'(c))
              spi_act_q[i] <= 1'b0;
        end
        if (grant_i[c]) begin
          for (int i = 0; i < SGI_N; i++)
            if (grant_id_i[c] == ID_W'(i)) begin
              sgi_pend_q[c][i] <= 1'b0;
              sgi_act_q[c][i]  <= 1'b1;
            end
          if (grant_id_i[c] == ID_W'(ID_TIMER)) begin
            ppi_pend_q[c][0] <= 1'b0; ppi_act_q[c][0] <= 1'b1;
          end
          if (grant_id_i[c] == ID_W'(ID_WDOG)) begin
            ppi_pend_q[c][1] <= 1'b0; ppi_act_q[c][1] <= 1'b1;
          end
          for (int i = 0; i < NUM_SPI; i++)
            if (grant_id_i[c] == ID_W'(SPI_BASE + i)) begin
              spi_pend_q[i] <= 1'b0;
              spi_act_q[i]  <= 1'b1;
              spi_own_q[i]  <= CPU_W'(c);
            end
        end
        // new requests land after clears so a same-cycle edge is kept
        if (timer_i[c] && !tmr_q[c]) ppi_pend_q[c][0] <= 1'b1;
        if (wdog_i[c]  && !wdg_q[c]) ppi_pend_q[c][1] <= 1'b1;
        if (sgi_vld_i && sgi_tgt_i[c])
          for (int i = 0; i < SGI_N; i++)
            if (sgi_id_i == 4'(i)) begin
              sgi_pend_q[c][i] <= 1'b1;
              sgi_src_o[c][i]  <= sgi_src_i;
            end
      end
      for (int i = 0; i < NUM_SPI; i++)
        if (spi_i[i] && !spi_q[i]) spi_pend_q[i] <= 1'b1;
    end
  end

  always_comb begin
    pend_o = '0;
    act_o  = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      pend_o[c][SGI_N-1:0] = sgi_pend_q[c];
      act_o[c][SGI_N-1:0]  = sgi_act_q[c];
      pend_o[c][ID_TIMER]  = ppi_pend_q[c][0];
      pend_o[c][ID_WDOG]   = ppi_pend_q[c][1];
      act_o[c][ID_TIMER]   = ppi_act_q[c][0];
      act_o[c][ID_WDOG]    = ppi_act_q[c][1];
      for (int i = 0; i < NUM_SPI; i++) begin
        pend_o[c][SPI_BASE+i] = spi_pend_q[i] && tgt_i[i][c];
        act_o[c][SPI_BASE+i]  = spi_act_q[i] && (spi_own_q[i] == CPU_W'(c));
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_grant_activates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_i[c] && grant_id_i[c] == ID_W'(ID_TIMER)) |=> ppi_act_q[c][0]);
    p_sgi_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sgi_vld_i && sgi_tgt_i[c]) |=> sgi_pend_q[c][$past(sgi_id_i)]);
  end
endmodule

// File: rtl/mpid_cpu_sel.sv
module mpid_cpu_sel
  import mpid_pkg::*;
#(
  parameter int NUM_SPI = 8,
  localparam int TOTAL  = SPI_BASE + NUM_SPI
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [TOTAL-1:0]              pend_i,
  input  logic [TOTAL-1:0]              act_i,
  input  logic [TOTAL-1:0]              en_i,
  input  logic [TOTAL-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]             mask_i,
  input  logic [1:0]                    bp_i,
  output logic [ID_W-1:0]               hp_id_o,
  output logic                          irq_o
);
  logic              best_vld;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W:0]   run_prio, grp_new, grp_run;

  always_comb begin
    best_vld  = 1'b0;
    best_prio = '1;
    best_id   = SPURIOUS;
    run_prio  = 5'd16;  // idle: above every real level
    for (int i = 0; i < TOTAL; i++) begin
      if (pend_i[i] && en_i[i] && (!best_vld || prio_i[i] < best_prio)) begin
        best_vld  = 1'b1;
        best_prio = prio_i[i];
        best_id   = ID_W'(i);
      end
      if (act_i[i] && {1'b0, prio_i[i]} < run_prio) run_prio = {1'b0, prio_i[i]};
    end
    grp_new = {1'b0, best_prio} >> bp_i;
    grp_run = run_prio >> bp_i;
    irq_o   = best_vld && (best_prio < mask_i) && (grp_new < grp_run);
    hp_id_o = irq_o ? best_id : SPURIOUS;
  end

  p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend_i & en_i));
endmodule

// File: rtl/mpid_top.sv
module mpid_top
  import mpid_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 8,
  localparam int SPI_W  = (NUM_SPI > 0) ? NUM_SPI : 1,
  localparam int TOTAL  = SPI_BASE + NUM_SPI
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [9:0]               reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  input  logic [1:0]               reg_cpu_i,
  output logic [31:0]              reg_rdata_o,
  input  logic [SPI_W-1:0]         spi_i,
  input  logic [NUM_CPU-1:0]       timer_i,
  input  logic [NUM_CPU-1:0]       wdog_i,
  output logic [NUM_CPU-1:0]       irq_o,
  input  logic [NUM_CPU-1:0]       ack_i,
  output logic [NUM_CPU*10-1:0]    ack_id_o,
  output logic [NUM_CPU*2-1:0]     ack_src_o,
  input  logic [NUM_CPU-1:0]       eoi_i,
  input  logic [NUM_CPU*10-1:0]    eoi_id_i
);
  logic [TOTAL-1:0]                     en;
  logic [TOTAL-1:0][PRIO_W-1:0]         prio;
  logic [SPI_W-1:0][NUM_CPU-1:0]        tgt;
  logic [NUM_CPU-1:0][PRIO_W-1:0]       mask;
  logic [NUM_CPU-1:0][1:0]              bp;
  logic                                 sgi_vld;
  logic [3:0]                           sgi_id;
  logic [NUM_CPU-1:0]                   sgi_tgt;
  logic [CPU_W-1:0]                     sgi_src;
  logic [NUM_CPU-1:0][TOTAL-1:0]        pend_v, act_v;
  logic [NUM_CPU-1:0][SGI_N-1:0][CPU_W-1:0] sgi_src_tab;
  logic [NUM_CPU-1:0][ID_W-1:0]         hp_id, eoi_id, ack_id_q;
  logic [NUM_CPU-1:0][CPU_W-1:0]        src_sel, ack_src_q;
  logic [NUM_CPU-1:0]                   grant;

  mpid_regs #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cpu_i(reg_cpu_i), .rdata_o(reg_rdata_o), .en_o(en), .prio_o(prio), .tgt_o(tgt),
    .mask_o(mask), .bp_o(bp), .sgi_vld_o(sgi_vld), .sgi_id_o(sgi_id),
    .sgi_tgt_o(sgi_tgt), .sgi_src_o(sgi_src));

  mpid_state #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_state (
    .clk_i, .rst_ni, .spi_i, .timer_i, .wdog_i, .tgt_i(tgt),
    .sgi_vld_i(sgi_vld), .sgi_id_i(sgi_id), .sgi_tgt_i(sgi_tgt), .sgi_src_i(sgi_src),
    .grant_i(grant), .grant_id_i(hp_id), .eoi_i, .eoi_id_i(eoi_id),
    .pend_o(pend_v), .act_o(act_v), .sgi_src_o(sgi_src_tab));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign eoi_id[c] = eoi_id_i[c*ID_W +: ID_W];
    assign ack_id_o[c*ID_W +: ID_W]    = ack_id_q[c];
    assign ack_src_o[c*CPU_W +: CPU_W] = ack_src_q[c];

    mpid_cpu_sel #(.NUM_SPI(NUM_SPI)) u_sel (
      .clk_i, .rst_ni, .pend_i(pend_v[c]), .act_i(act_v[c]), .en_i(en),
      .prio_i(prio), .mask_i(mask[c]), .bp_i(bp[c]), .hp_id_o(hp_id[c]),
      .irq_o(irq_o[c]));
  end

  // lower CPU index wins a shared ID claimed by several CPUs at once
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      grant[c]   = ack_i[c] && (hp_id[c] != SPURIOUS);
      for (int k = 0; k < c; k++)
        if (grant[k] && hp_id[k] == hp_id[c] && hp_id[c] >= ID_W'(SPI_BASE))
          grant[c] = 1'b0;
      src_sel[c] = '0;
      for (int i = 0; i < SGI_N; i++)
        if (hp_id[c] == ID_W'(i)) src_sel[c] = sgi_src_tab[c][i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CPU; c++) ack_id_q[c] <= SPURIOUS;
      ack_src_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        if (ack_i[c]) begin
          ack_id_q[c]  <= grant[c] ? hp_id[c] : SPURIOUS;
          ack_src_q[c] <= grant[c] ? src_sel[c] : '0;
        end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_top_chk
    p_spur_when_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && !irq_o[c]) |=> ack_id_q[c] == SPURIOUS);
    if (c > 0) begin : g_race
      p_one_winner_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[c] && ack_i[0] && irq_o[0] && hp_id[c] == hp_id[0] &&
         hp_id[0] >= ID_W'(SPI_BASE)) |=> ack_id_q[c] == SPURIOUS);
    end
  end
endmodule

// File: tb/mpid_top_tb.sv
module mpid_top_tb;
  localparam int NC = 2;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] rcpu = '0;
  logic [NS-1:0] spi = '0;
  logic [NC-1:0] tmr = '0, wdg = '0, irq, ack = '0, eoi = '0;
  logic [NC*10-1:0] ack_id, eoi_id = '0;
  logic [NC*2-1:0] ack_src;
  int vec = 0, miss = 0;

  always #5 clk = ~clk;

  mpid_top #(.NUM_CPU(NC), .NUM_SPI(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_cpu_i(rcpu), .reg_rdata_o(rdata), .spi_i(spi),
    .timer_i(tmr), .wdog_i(wdg), .irq_o(irq), .ack_i(ack), .ack_id_o(ack_id),
    .ack_src_o(ack_src), .eoi_i(eoi), .eoi_id_i(eoi_id));

  task automatic step; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    vec++;
    if (a !== e) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] c = 0);
    we = 1'b1; addr = a; wdata = d; rcpu = c; step; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_ack(input int c, output logic [9:0] id, output logic [1:0] src);
    ack[c] = 1'b1; step; ack[c] = 1'b0;
    id = ack_id[c*10 +: 10]; src = ack_src[c*2 +: 2];
  endtask

  task automatic do_eoi(input int c, input logic [9:0] id);
    eoi[c] = 1'b1; eoi_id[c*10 +: 10] = id; step; eoi[c] = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    spi = m; step; spi = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [9:0] id; logic [1:0] s;
    chk("R1 irq idle", 32'(irq), 0);
    rd(10'd33, d); chk("R1 cfg reset", d, 0);
    rd(10'h3F8, d); chk("R1 cpu settings reset", d, 32'h00F);
    do_ack(0, id, s); chk("R1 ack spurious", 32'(id), 1023);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(10'd33, 32'h251); rd(10'd33, d); chk("R2 shared cfg", d, 32'h251);
    wr(10'd3, 32'h351);  rd(10'd3, d);  chk("R2 target ignored below 32", d, 32'h051);
    wr(10'h3F9, 32'h205); rd(10'h3F9, d); chk("R2 cpu settings", d, 32'h205);
    wr(10'h3F9, 32'h00F);
  endtask

  task automatic t_route;
    logic [9:0] id; logic [1:0] s;
    pulse(8'b0000_0010);
    chk("R3 routed to target only", 32'(irq), 2'b10);
    do_ack(1, id, s);
    chk("R7 ack id", 32'(id), 33); chk("R7 ack src hw", 32'(s), 0);
    chk("R7 irq drops after ack", 32'(irq), 0);
    do_eoi(1, 10'd33);
  endtask

  task automatic t_prio;
    logic [9:0] id; logic [1:0] s;
    wr(10'd34, 32'h161); wr(10'd35, 32'h131); wr(10'd36, 32'h131);
    pulse(8'b0001_1100);
    chk("R4 irq", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R4 lowest prio, lowest id", 32'(id), 35);
    chk("R8 equal group no preempt", 32'(irq), 0);
    do_eoi(0, 10'd35);
    do_ack(0, id, s); chk("R4 tie next", 32'(id), 36);
    do_eoi(0, 10'd36);
    do_ack(0, id, s); chk("R4 last", 32'(id), 34);
    do_eoi(0, 10'd34);
  endtask

  task automatic t_mask;
    logic [9:0] id; logic [1:0] s;
    wr(10'h3F8, 32'h004); wr(10'd37, 32'h141);
    pulse(8'b0010_0000);
    chk("R5 masked", 32'(irq), 0);
    do_ack(0, id, s); chk("R5 ack spurious when masked", 32'(id), 1023);
    wr(10'h3F8, 32'h005);
    chk("R5 unmasked", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R5 ack after unmask", 32'(id), 37);
    do_eoi(0, 10'd37); wr(10'h3F8, 32'h00F);
  endtask

  task automatic t_disabled;
    logic [9:0] id; logic [1:0] s;
    wr(10'd38, 32'h120);
    pulse(8'b0100_0000);
    chk("R6 disabled silent", 32'(irq), 0);
    wr(10'd38, 32'h121);
    chk("R6 enable delivers", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R6 ack", 32'(id), 38);
    do_eoi(0, 10'd38);
  endtask

  task automatic t_preempt;
    logic [9:0] id; logic [1:0] s;
    wr(10'd35, 32'h151); wr(10'd36, 32'h141); wr(10'h3F8, 32'h20F);
    pulse(8'b0000_1000);
    do_ack(0, id, s); chk("R8 first", 32'(id), 35);
    pulse(8'b0001_0000);
    chk("R8 same group blocked bp2", 32'(irq), 0);
    wr(10'h3F8, 32'h00F);
    chk("R8 preempt bp0", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R8 nested ack", 32'(id), 36);
    do_eoi(0, 10'd36);
    pulse(8'b0001_0000);
    chk("R9 running prio restored", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R9 re-ack", 32'(id), 36);
    do_eoi(0, 10'd36); do_eoi(0, 10'd35);
    chk("R9 all retired", 32'(irq), 0);
  endtask

  task automatic t_sgi;
    logic [9:0] id; logic [1:0] s;
    wr(10'd5, 32'h011);
    wr(10'h3F0, 32'h0001_0005, 2'd0);
    chk("R10 others", 32'(irq), 2'b10);
    do_ack(1, id, s); chk("R10 others id", 32'(id), 5); chk("R10 others src", 32'(s), 0);
    do_eoi(1, 10'd5);
    wr(10'h3F0, 32'h0002_0005, 2'd1);
    chk("R10 self", 32'(irq), 2'b10);
    do_ack(1, id, s); chk("R10 self id", 32'(id), 5); chk("R10 self src", 32'(s), 1);
    do_eoi(1, 10'd5);
    wr(10'h3F0, 32'h0000_0105, 2'd1);
    chk("R10 list", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R10 list id", 32'(id), 5); chk("R10 list src", 32'(s), 1);
    do_eoi(0, 10'd5);
    wr(10'h3F0, 32'h0003_0305, 2'd0);
    chk("R10 mode none", 32'(irq), 0);
  endtask

  task automatic t_private;
    logic [9:0] id; logic [1:0] s;
    wr(10'd29, 32'h021); wr(10'd30, 32'h011);
    tmr[1] = 1'b1; step;
    chk("R11 timer local", 32'(irq), 2'b10);
    do_ack(1, id, s); chk("R11 timer id", 32'(id), 29);
    do_eoi(1, 10'd29); tmr[1] = 1'b0;
    wdg[0] = 1'b1; step;
    chk("R11 wdog local", 32'(irq), 2'b01);
    do_ack(0, id, s); chk("R11 wdog id", 32'(id), 30);
    do_eoi(0, 10'd30); wdg[0] = 1'b0; step;
  endtask

  task automatic t_race;
    wr(10'd39, 32'h321);
    pulse(8'b1000_0000);
    chk("R12 both see", 32'(irq), 2'b11);
    ack = 2'b11; step; ack = 2'b00;
    chk("R12 cpu0 wins", 32'(ack_id[9:0]), 39);
    chk("R12 cpu1 spurious", 32'(ack_id[19:10]), 1023);
    chk("R12 irq cleared", 32'(irq), 0);
    do_eoi(0, 10'd39);
  endtask

  initial begin
    #1_000_000;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    #21 rst_n = 1'b1;
    step;
    t_reset; t_cfg; t_route; t_prio; t_mask; t_disabled;
    t_preempt; t_sgi; t_private; t_race;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule